// File: doc/BRIEF.md
# Prioritized Pending Interrupt Arbiter

This block holds one pending flag per asynchronous interrupt source and offers at most one of them at a time to the exception entry logic. Timers, external pins and doorbell messages post requests through a set vector and withdraw them through a clear vector. Each cycle the arbiter masks the pending flags with two enable bits taken from the machine state: a critical enable and an external enable. Among the sources that remain, it picks the one with the best rank.

The chosen source is presented as a code on a valid/ready handshake. The code is the source's rank, so 0 is the most urgent. Once an offer is made it does not change until it is accepted. On acceptance, the pending flag of a pulse-type source is consumed. A level-type source keeps its flag, because its status is owned by the requester. The hypervisor decrementer has a pending flag, but its enable is tied off, so it can never be chosen.

Source ranks, which are also the bit positions in the set, clear and pending vectors and the delivered code:
0 system reset, 1 machine check, 2 hypervisor decrementer, 3 critical external, 4 watchdog, 5 critical doorbell, 6 fixed-interval timer, 7 programmable-interval timer, 8 decrementer, 9 external, 10 doorbell, 11 performance monitor, 12 thermal.

Top module: `irq_arbiter`

## Requirements
- R1: While reset is asserted and after it is released, the pending vector is all zero and no offer is valid.
- R2: Codes 0 (system reset) and 1 (machine check) are eligible whatever the state of both enable inputs.
- R3: Code 3 (critical external) is eligible only while the critical enable input is 1.
- R4: Codes 4 to 12 are eligible only while the external enable input is 1.
- R5: When several sources are eligible, the offer carries the smallest eligible code.
- R6: Code 2 (hypervisor decrementer) can be set pending but is never offered.
- R7: When an offer is accepted (valid and ready both high at a clock edge), the pending bit of that code is cleared at that edge. Codes 3 and 9 are the exception: their pending bits stay set.
- R8: A set input raises its pending bit at the next edge. A clear input drops it at the next edge. A set and a clear of the same bit in the same cycle leave the bit set.
- R9: A valid offer keeps its code unchanged until it is accepted, even if a better source arrives or the enables change. In the cycle after acceptance, no offer is valid.
- R10: When no offer is outstanding, an offer becomes valid one edge after the pending vector shows an eligible source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| set_i | input | 13 | Per-source request post, bit index = rank |
| clr_i | input | 13 | Per-source request withdraw, bit index = rank |
| crit_en_i | input | 1 | Critical enable from machine state |
| ext_en_i | input | 1 | External enable from machine state |
| irq_ready_i | input | 1 | Exception entry accepts the offer |
| irq_valid_o | output | 1 | Offer valid |
| irq_code_o | output | 4 | Offered source rank |
| pend_o | output | 13 | Current pending vector |

## Verification
The bench sweeps every one of the 8192 pending patterns. Each pattern runs under a rotating combination of the two enables and is accepted once, so the bench sees both the winner and the pending vector that remains. This sweep catches these faults:
- A design that forgets a gate offers critical or timer sources while they are masked.
- A priority encoder scanning the wrong way picks the worst rank.
- A design that consumes level sources loses the external status after its first delivery.
- A design that lets the tied-off hypervisor source through offers code 2.

Directed sequences cover three further cases. A better source that arrives during an unaccepted offer must not replace it; a design that re-arbitrates every cycle would switch codes under the consumer. A set and a clear of the same bit in one cycle must leave the bit set; a design that gives clear priority would drop the request.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int NSRC   = 13;
  localparam int CODE_W = $clog2(NSRC);

  typedef enum logic [1:0] {
    GATE_NONE,
    GATE_OFF,
    GATE_CRIT,
    GATE_EXT
  } gate_e;

  localparam int SRC_HDEC = 2;
  localparam int SRC_CEXT = 3;
  localparam int SRC_EXT  = 9;

  function automatic gate_e gate_of(input int idx);
    if (idx < SRC_HDEC)       return GATE_NONE;
    else if (idx == SRC_HDEC) return GATE_OFF;
    else if (idx == SRC_CEXT) return GATE_CRIT;
    else                      return GATE_EXT;
  endfunction

  function automatic logic [NSRC-1:0] level_mask();
    logic [NSRC-1:0] m;
    m = '0;
    m[SRC_CEXT] = 1'b1;
    m[SRC_EXT]  = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/irq_arb_pend.sv
module irq_arb_pend
  import irq_arb_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] set_i,
  input  logic [NSRC-1:0] clr_i,
  input  logic [NSRC-1:0] consume_i,
  output logic [NSRC-1:0] pend_o
);
  logic [NSRC-1:0] pend_q, pend_d;

  always_comb begin
    pend_d = (pend_q & ~(clr_i | consume_i)) | set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irq_arb_gate.sv
module irq_arb_gate
  import irq_arb_pkg::*;
(
  input  logic [NSRC-1:0] pend_i,
  input  logic            crit_en_i,
  input  logic            ext_en_i,
  output logic [NSRC-1:0] elig_o
);
  for (genvar g = 0; g < NSRC; g++) begin : g_src
    if (gate_of(g) == GATE_NONE) begin : g_nmi
      assign elig_o[g] = pend_i[g];
    end else if (gate_of(g) == GATE_OFF) begin : g_off
      assign elig_o[g] = 1'b0;
    end else if (gate_of(g) == GATE_CRIT) begin : g_crit
      assign elig_o[g] = pend_i[g] & crit_en_i;
    end else begin : g_ext
      assign elig_o[g] = pend_i[g] & ext_en_i;
    end
  end
endmodule

// File: rtl/irq_arb_pick.sv
module irq_arb_pick
  import irq_arb_pkg::*;
(
  input  logic [NSRC-1:0]   elig_i,
  output logic              found_o,
  output logic [CODE_W-1:0] code_o
);
  always_comb begin
    found_o = 1'b0;
    code_o  = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (elig_i[i]) begin
        found_o = 1'b1;
        code_o  = CODE_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_arb_offer.sv
module irq_arb_offer
  import irq_arb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              found_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              ready_i,
  output logic              valid_o,
  output logic [CODE_W-1:0] code_o
);
  logic              valid_q, valid_d;
  logic [CODE_W-1:0] code_q, code_d;
  logic              code_en;

  always_comb begin
    valid_d = valid_q;
    code_d  = code_q;
    code_en = 1'b0;
    if (valid_q) begin
      if (ready_i) valid_d = 1'b0;
    end else begin
      valid_d = found_i;
      code_d  = code_i;
      code_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      code_q  <= '0;
    end else begin
      valid_q <= valid_d;
      if (code_en) code_q <= code_d;
    end
  end

  assign valid_o = valid_q;
  assign code_o  = code_q;
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_arb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   set_i,
  input  logic [NSRC-1:0]   clr_i,
  input  logic              crit_en_i,
  input  logic              ext_en_i,
  input  logic              irq_ready_i,
  output logic              irq_valid_o,
  output logic [CODE_W-1:0] irq_code_o,
  output logic [NSRC-1:0]   pend_o
);
  localparam logic [NSRC-1:0] LEVEL = level_mask();

  logic [NSRC-1:0]   pend, elig, consume;
  logic              found;
  logic [CODE_W-1:0] pick_code;
  logic              accept;

  assign accept = irq_valid_o & irq_ready_i;

  always_comb begin
    consume = '0;
    if (accept) consume[irq_code_o] = 1'b1;
    consume = consume & ~LEVEL;
  end

  irq_arb_pend u_pend (
    .clk(clk), .rst_n(rst_n), .set_i(set_i), .clr_i(clr_i),
    .consume_i(consume), .pend_o(pend)
  );

  irq_arb_gate u_gate (
    .pend_i(pend), .crit_en_i(crit_en_i), .ext_en_i(ext_en_i), .elig_o(elig)
  );

  irq_arb_pick u_pick (
    .elig_i(elig), .found_o(found), .code_o(pick_code)
  );

  irq_arb_offer u_offer (
    .clk(clk), .rst_n(rst_n), .found_i(found), .code_i(pick_code),
    .ready_i(irq_ready_i), .valid_o(irq_valid_o), .code_o(irq_code_o)
  );

  assign pend_o = pend;
endmodule

// File: rtl/irq_arbiter_chk.sv
module irq_arbiter_chk
  import irq_arb_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [NSRC-1:0]   set_i,
  input logic [NSRC-1:0]   clr_i,
  input logic              crit_en_i,
  input logic              ext_en_i,
  input logic              irq_ready_i,
  input logic              irq_valid_o,
  input logic [CODE_W-1:0] irq_code_o,
  input logic [NSRC-1:0]   pend_o
);
  a_r1_idle_in_reset: assert property (@(posedge clk)
    !rst_n |-> (!irq_valid_o && pend_o == '0));

  a_r6_hdec_never: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid_o |-> irq_code_o != CODE_W'(SRC_HDEC));

  a_r3_crit_gated: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(irq_valid_o) && irq_code_o == CODE_W'(SRC_CEXT)) |-> $past(crit_en_i));

  a_r4_ext_gated: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(irq_valid_o) && irq_code_o > CODE_W'(SRC_CEXT)) |-> $past(ext_en_i));

  a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid_o && !irq_ready_i) |=> (irq_valid_o && $stable(irq_code_o)));

  a_r9_gap_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid_o && irq_ready_i) |=> !irq_valid_o);

  a_r7_ext_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid_o && irq_ready_i && irq_code_o == CODE_W'(SRC_EXT) && !clr_i[SRC_EXT])
      |=> pend_o[SRC_EXT]);

  a_r7_decr_consumed: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid_o && irq_ready_i && irq_code_o == CODE_W'(8) && !set_i[8]) |=> !pend_o[8]);

  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i != '0) |=> ((pend_o & $past(set_i)) == $past(set_i)));
endmodule

bind irq_arbiter irq_arbiter_chk chk_i (
  .clk(clk), .rst_n(rst_n), .set_i(set_i), .clr_i(clr_i),
  .crit_en_i(crit_en_i), .ext_en_i(ext_en_i), .irq_ready_i(irq_ready_i),
  .irq_valid_o(irq_valid_o), .irq_code_o(irq_code_o), .pend_o(pend_o)
);

// File: tb/irq_arbiter_tb_top.sv
`timescale 1ns/1ps
module irq_arbiter_tb_top;
  import irq_arb_pkg::*;
  localparam int N = NSRC;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic              rst_n;
  logic [N-1:0]      set_i, clr_i, pend_o;
  logic              crit_en_i, ext_en_i, irq_ready_i, irq_valid_o;
  logic [CODE_W-1:0] irq_code_o;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  finished = 0;

  irq_arbiter dut_i (
    .clk(clk), .rst_n(rst_n), .set_i(set_i), .clr_i(clr_i),
    .crit_en_i(crit_en_i), .ext_en_i(ext_en_i), .irq_ready_i(irq_ready_i),
    .irq_valid_o(irq_valid_o), .irq_code_o(irq_code_o), .pend_o(pend_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int winner(input logic [N-1:0] p, input logic ce, input logic ee);
    for (int k = 0; k < N; k++) begin
      if (p[k]) begin
        if (k <= 1) return k;
        if (k == 3 && ce) return k;
        if (k >= 4 && ee) return k;
      end
    end
    return -1;
  endfunction

  task automatic step();
    @(negedge clk);
  endtask

  task automatic report();
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      report();
    end
  end

  initial begin
    rst_n = 1'b0; set_i = '0; clr_i = '0;
    crit_en_i = 1'b0; ext_en_i = 1'b0; irq_ready_i = 1'b0;
    repeat (3) step();
    chk("R1 pend in reset", 32'(pend_o), 0);
    chk("R1 valid in reset", 32'(irq_valid_o), 0);
    rst_n = 1'b1;
    step();
    chk("R1 pend after reset", 32'(pend_o), 0);
    chk("R1 valid after reset", 32'(irq_valid_o), 0);

    // sweep every pending pattern
    for (int p = 0; p < (1 << N); p++) begin
      logic [N-1:0] pat;
      logic [1:0]   en;
      int           w;
      logic [N-1:0] left;
      string        tag;
      pat = N'(p);
      en  = 2'((p * 5 + p / 3) % 4);
      clr_i = '1; irq_ready_i = 1'b1; set_i = '0;
      step(); step();
      clr_i = '0; irq_ready_i = 1'b0; set_i = pat;
      crit_en_i = en[0]; ext_en_i = en[1];
      step();
      set_i = '0;
      chk("R8 pend after set", 32'(pend_o), 32'(pat));
      step();
      w = winner(pat, en[0], en[1]);
      if (w < 0)       tag = "R6 no eligible";
      else if (w <= 1) tag = "R2 ungated";
      else if (w == 3) tag = "R3 critical";
      else             tag = "R4 external class";
      chk({tag, " valid R10"}, 32'(irq_valid_o), (w >= 0) ? 1 : 0);
      if (w >= 0) chk({tag, " code R5"}, 32'(irq_code_o), 32'(w));
      irq_ready_i = 1'b1;
      step();
      irq_ready_i = 1'b0;
      left = pat;
      if (w >= 0 && w != 3 && w != 9) left[w] = 1'b0;
      chk("R7 pend after accept", 32'(pend_o), 32'(left));
      chk("R9 gap after accept", 32'(irq_valid_o), 0);
    end

    // drain
    clr_i = '1; irq_ready_i = 1'b1;
    step(); step();
    clr_i = '0; irq_ready_i = 1'b0;

    // hold-stable: decrementer offered, reset arrives while waiting
    crit_en_i = 1'b0; ext_en_i = 1'b1;
    set_i = N'(1) << 8;
    step();
    set_i = '0;
    step();
    chk("R10 offer valid", 32'(irq_valid_o), 1);
    chk("R10 offer code", 32'(irq_code_o), 8);
    set_i = N'(1);
    step();
    set_i = '0;
    ext_en_i = 1'b0;
    for (int i = 0; i < 3; i++) begin
      chk("R9 held valid", 32'(irq_valid_o), 1);
      chk("R9 held code", 32'(irq_code_o), 8);
      step();
    end
    irq_ready_i = 1'b1;
    step();
    irq_ready_i = 1'b0;
    chk("R9 no offer after accept", 32'(irq_valid_o), 0);
    chk("R7 decrementer consumed", 32'(pend_o), 1);
    step();
    chk("R2 reset offered", 32'(irq_valid_o), 1);
    chk("R2 reset code", 32'(irq_code_o), 0);
    irq_ready_i = 1'b1;
    step();
    irq_ready_i = 1'b0;
    chk("R7 reset consumed", 32'(pend_o), 0);

    // set and clear together, then clear alone
    set_i = N'(1) << 6; clr_i = N'(1) << 6;
    step();
    set_i = '0; clr_i = '0;
    chk("R8 set beats clear", 32'(pend_o[6]), 1);
    clr_i = N'(1) << 6;
    step();
    clr_i = '0;
    chk("R8 clear drops bit", 32'(pend_o[6]), 0);

    // level source re-offered repeatedly
    ext_en_i = 1'b1;
    set_i = N'(1) << 9;
    step();
    set_i = '0;
    for (int i = 0; i < 2; i++) begin
      step();
      chk("R7 external re-offered", 32'(irq_code_o), 9);
      chk("R7 external valid", 32'(irq_valid_o), 1);
      irq_ready_i = 1'b1;
      step();
      irq_ready_i = 1'b0;
      chk("R7 external still pending", 32'(pend_o[9]), 1);
    end

    finished = 1;
    report();
  end
endmodule